// File: doc/BRIEF.md
# Masked-Search Content-Addressable Memory

This block is a small associative store: entries are located by what they hold, not by where they sit. Each entry is one word built from three fields, a 12-bit key in the top bits, a 4-bit class in the middle and an 8-bit payload in the low bits. Entries are written by index with a flag that either stores a valid word or invalidates the slot. A controller side holds a comparand register and a mask register, both driven to every entry at once.

A search strobe makes every entry compare its word with the comparand in the same cycle. Only the bit positions set in the mask take part, so a mask that covers one field searches by that field alone. Each entry keeps the outcome in its own tag bit. A gathering stage turns the match vector into four results: a hit flag, the index of the lowest matching entry, that entry's full word and the number of matches. Tags and results are registered together on the search edge and hold until the next search.

Top module: `masked_cam`

## Requirements
- R1: After a synchronous active-low reset, every tag, `hit`, `hit_idx`, `hit_data`, `hit_cnt` and `done` is zero, the comparand and mask are zero, and no entry is valid, so a search straight after reset finds nothing.
- R2: A write with `wr_en` high stores `wr_data` into entry `wr_idx` and marks it valid when `wr_valid` is 1; with `wr_valid` 0 it marks the entry invalid.
- R3: `cmp_ld` loads `ld_data` into the comparand and `msk_ld` loads it into the mask; a load in the same cycle as a search strobe affects only later searches.
- R4: An entry matches when it is valid and `((word ^ comparand) & mask) == 0`; a mask of all zeros therefore matches every valid entry, and a mask of one field (key `[23:12]`, class `[11:8]`, payload `[7:0]`) searches by that field only.
- R5: An invalid entry never sets its tag bit, whatever the comparand and mask.
- R6: Tags and all gathered results change only on the clock edge at which `srch` is high, become visible in the cycle after the strobe together with a one-cycle `done` pulse, and keep their values until the next strobe.
- R7: When at least one entry matches, `hit` is 1, `hit_idx` is the lowest matching index and `hit_data` is that entry's whole word.
- R8: `hit_cnt` equals the number of entries whose tag is set by the search.
- R9: When no entry matches, `hit`, `hit_idx`, `hit_data` and `hit_cnt` are all zero.
- R10: A write issued in the same cycle as a search strobe lands after the compare: that search and its gathered data see the old contents and validity, and the next search sees the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one entry |
| wr_valid | input | 1 | 1 stores the word as valid, 0 invalidates the entry |
| wr_idx | input | IDX_W | Entry written |
| wr_data | input | WORD_W | Word written |
| cmp_ld | input | 1 | Load comparand from ld_data |
| msk_ld | input | 1 | Load mask from ld_data |
| ld_data | input | WORD_W | Value for comparand or mask loads |
| srch | input | 1 | Search strobe |
| tags | output | ENTRIES | Per-entry match bits of the last search |
| done | output | 1 | One-cycle pulse in the cycle after a strobe |
| hit | output | 1 | At least one entry matched |
| hit_idx | output | IDX_W | Lowest matching index |
| hit_data | output | WORD_W | Word of the lowest matching entry |
| hit_cnt | output | CNT_W | Number of matching entries |

## Verification
The assertions assume the tag vector and the gathered results are produced from one and the same compare, so they tie `hit`, `hit_idx`, `hit_cnt` and the zero-on-miss values directly to `tags` in every cycle, and expect nothing to move while `srch` is low. They take no view of which entry should match; that is left to the bench's own model of stored words, validity, comparand and mask. The stimulus drives one load at a time from its shared data bus, holds every input steady across the active edge, and only overlaps a load or a write with a strobe in the two dedicated cases that probe ordering.

// File: rtl/mcam_pkg.sv
// Shared constants for the masked-search CAM.
// Assumes a word is three fields packed key:class:payload, most significant first.
package mcam_pkg;
    localparam int unsigned KEY_W  = 12;
    localparam int unsigned CLS_W  = 4;
    localparam int unsigned PAY_W  = 8;
    localparam int unsigned WORD_W = KEY_W + CLS_W + PAY_W;

    // Bit offsets of each field inside a word.
    localparam int unsigned PAY_LSB = 0;
    localparam int unsigned CLS_LSB = PAY_W;
    localparam int unsigned KEY_LSB = PAY_W + CLS_W;

    // Builds a mask that covers one field of given width and offset.
    function automatic logic [WORD_W-1:0] field_mask(input int unsigned lsb, input int unsigned width);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int unsigned b = 0; b < WORD_W; b++) begin
            if (b >= lsb && b < lsb + width) m[b] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/mcam_ctrl.sv
// Central control registers: comparand and mask, broadcast to all entries.
// Assumes loads share one data bus; a load takes effect for the next edge onward.
module mcam_ctrl #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_ld,
    input  logic         msk_ld,
    input  logic [W-1:0] ld_data,
    output logic [W-1:0] cmp_q,
    output logic [W-1:0] msk_q
);
    // Comparand register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_ld) cmp_q <= ld_data;
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)      msk_q <= '0;
        else if (msk_ld) msk_q <= ld_data;
    end
endmodule

// File: rtl/mcam_cell.sv
// One CAM entry: stored word, valid bit, masked comparator and tag bit.
// Assumes comparand and mask are stable registers; the compare uses the
// word as held before any write on the same edge.
module mcam_cell #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_sel,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    input  logic         srch,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] msk,
    output logic [W-1:0] word_q,
    output logic         match_now,
    output logic         tag_q
);
    logic valid_q;

    // Word storage; an invalidate leaves the old word in place.
    always_ff @(posedge clk) begin
        if (!rst_n)                  word_q <= '0;
        else if (wr_sel && wr_valid) word_q <= wr_data;
    end

    // Valid bit follows the write flag.
    always_ff @(posedge clk) begin
        if (!rst_n)      valid_q <= 1'b0;
        else if (wr_sel) valid_q <= wr_valid;
    end

    // Masked compare of the current contents.
    always_comb begin
        match_now = valid_q && (((word_q ^ cmp) & msk) == '0);
    end

    // Tag captures the compare only on a search edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    tag_q <= 1'b0;
        else if (srch) tag_q <= match_now;
    end
endmodule

// File: rtl/mcam_gather.sv
// Data-gathering stage: lowest-index priority pick, word select and match count.
// Assumes the match vector and words come from the same cycle as the strobe;
// results are registered on that edge and held until the next strobe.
module mcam_gather #(
    parameter int unsigned N = 8,
    parameter int unsigned W = 24,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int unsigned CNT_W = $clog2(N + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                srch,
    input  logic [N-1:0]        match,
    input  logic [N-1:0][W-1:0] words,
    output logic                hit_q,
    output logic [IDX_W-1:0]    idx_q,
    output logic [W-1:0]        data_q,
    output logic [CNT_W-1:0]    cnt_q,
    output logic                done_q
);
    logic [IDX_W-1:0] first_idx;
    logic [W-1:0]     first_word;
    logic [CNT_W-1:0] count;
    logic             any;

    // Priority encoder: scan from the top so the lowest match wins.
    always_comb begin
        first_idx  = '0;
        first_word = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                first_idx  = IDX_W'(i);
                first_word = words[i];
            end
        end
    end

    // Population count of the match vector.
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CNT_W'(match[i]);
        end
        any = |match;
    end

    // Result registers, loaded only on a search edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            idx_q  <= '0;
            data_q <= '0;
            cnt_q  <= '0;
        end else if (srch) begin
            hit_q  <= any;
            idx_q  <= first_idx;
            data_q <= first_word;
            cnt_q  <= count;
        end
    end

    // Completion pulse one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= srch;
    end
endmodule

// File: rtl/masked_cam.sv
// Top of the masked-search CAM: control registers, an array of entries and
// the gathering stage. Assumes one write, one load of each register and one
// strobe at most per cycle.
module masked_cam
    import mcam_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned WORD_W  = mcam_pkg::WORD_W,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int unsigned CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_valid,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               cmp_ld,
    input  logic               msk_ld,
    input  logic [WORD_W-1:0]  ld_data,
    input  logic               srch,
    output logic [ENTRIES-1:0] tags,
    output logic               done,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [WORD_W-1:0]  hit_data,
    output logic [CNT_W-1:0]   hit_cnt
);
    logic [WORD_W-1:0]               cmp_q;
    logic [WORD_W-1:0]               msk_q;
    logic [ENTRIES-1:0]              match_now;
    logic [ENTRIES-1:0][WORD_W-1:0]  words;

    mcam_ctrl #(.W(WORD_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_ld  (cmp_ld),
        .msk_ld  (msk_ld),
        .ld_data (ld_data),
        .cmp_q   (cmp_q),
        .msk_q   (msk_q)
    );

    // One entry per index, each decoding its own write select.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));
        mcam_cell #(.W(WORD_W)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_sel    (sel),
            .wr_valid  (wr_valid),
            .wr_data   (wr_data),
            .srch      (srch),
            .cmp       (cmp_q),
            .msk       (msk_q),
            .word_q    (words[g]),
            .match_now (match_now[g]),
            .tag_q     (tags[g])
        );
    end

    mcam_gather #(.N(ENTRIES), .W(WORD_W)) u_gather (
        .clk    (clk),
        .rst_n  (rst_n),
        .srch   (srch),
        .match  (match_now),
        .words  (words),
        .hit_q  (hit),
        .idx_q  (hit_idx),
        .data_q (hit_data),
        .cnt_q  (hit_cnt),
        .done_q (done)
    );
endmodule

// File: rtl/masked_cam_chk.sv
// Checker for the masked-search CAM: ties gathered results to the tag bits.
// Assumes it is bound to masked_cam and sees its ports only.
module masked_cam_chk #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned WORD_W  = 24,
    parameter int unsigned IDX_W   = 3,
    parameter int unsigned CNT_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               srch,
    input logic [ENTRIES-1:0] tags,
    input logic               done,
    input logic               hit,
    input logic [IDX_W-1:0]   hit_idx,
    input logic [WORD_W-1:0]  hit_data,
    input logic [CNT_W-1:0]   hit_cnt
);
    logic [ENTRIES-1:0] below;

    // Entries with a lower index than the reported one.
    always_comb begin
        below = (ENTRIES'(1) << hit_idx) - ENTRIES'(1);
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (tags == '0) && !hit && !done && (hit_cnt == '0));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !srch |=> $stable(tags) && $stable(hit) && $stable(hit_idx)
                  && $stable(hit_data) && $stable(hit_cnt));

    p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        srch |=> done);

    p_hit_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit == (tags != '0));

    p_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> tags[hit_idx] && ((tags & below) == '0));

    p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        32'(hit_cnt) == $countones(tags));

    p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_idx == '0) && (hit_data == '0) && (hit_cnt == '0));
endmodule

bind masked_cam masked_cam_chk #(
    .ENTRIES (ENTRIES),
    .WORD_W  (WORD_W),
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .srch     (srch),
    .tags     (tags),
    .done     (done),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .hit_data (hit_data),
    .hit_cnt  (hit_cnt)
);

// File: tb/test_masked_cam.sv
module test_masked_cam;
    localparam int N  = 8;
    localparam int W  = 24;
    localparam int IW = 3;
    localparam int CW = 4;
    localparam logic [W-1:0] M_KEY = 24'hFFF000;
    localparam logic [W-1:0] M_CLS = 24'h000F00;
    localparam logic [W-1:0] M_PAY = 24'h0000FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_valid = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [W-1:0]  wr_data = '0;
    logic cmp_ld = 1'b0, msk_ld = 1'b0;
    logic [W-1:0]  ld_data = '0;
    logic srch = 1'b0;
    logic [N-1:0]  tags;
    logic done, hit;
    logic [IW-1:0] hit_idx;
    logic [W-1:0]  hit_data;
    logic [CW-1:0] hit_cnt;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [W-1:0] m_word [N];
    bit           m_val  [N];
    logic [W-1:0] m_cmp = '0, m_msk = '0;
    logic [N-1:0] e_tags;
    logic         e_hit;
    int           e_idx, e_cnt;
    logic [W-1:0] e_data;

    always #10 clk = ~clk;

    masked_cam #(.ENTRIES(N), .WORD_W(W)) i_masked_cam (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_valid(wr_valid),
        .wr_idx(wr_idx), .wr_data(wr_data), .cmp_ld(cmp_ld), .msk_ld(msk_ld),
        .ld_data(ld_data), .srch(srch), .tags(tags), .done(done), .hit(hit),
        .hit_idx(hit_idx), .hit_data(hit_data), .hit_cnt(hit_cnt)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Expected results from the model state.
    task automatic predict();
        e_tags = '0; e_hit = 1'b0; e_idx = 0; e_cnt = 0; e_data = '0;
        for (int i = 0; i < N; i++) begin
            if (m_val[i] && (((m_word[i] ^ m_cmp) & m_msk) == '0)) begin
                e_tags[i] = 1'b1;
                e_cnt++;
            end
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (e_tags[i]) begin e_hit = 1'b1; e_idx = i; e_data = m_word[i]; end
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "tags", 32'(tags), 32'(e_tags));
        chk(req, "hit", 32'(hit), 32'(e_hit));
        chk(req, "hit_idx", 32'(hit_idx), 32'(e_idx));
        chk(req, "hit_data", 32'(hit_data), 32'(e_data));
        chk(req, "hit_cnt", 32'(hit_cnt), 32'(e_cnt));
    endtask

    task automatic write(input int idx, input logic [W-1:0] d, input bit v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d; wr_valid = v;
        @(negedge clk);
        wr_en = 1'b0;
        m_val[idx] = v;
        if (v) m_word[idx] = d;
    endtask

    task automatic load(input logic [W-1:0] c, input logic [W-1:0] m);
        @(negedge clk);
        cmp_ld = 1'b1; ld_data = c;
        @(negedge clk);
        cmp_ld = 1'b0; msk_ld = 1'b1; ld_data = m;
        @(negedge clk);
        msk_ld = 1'b0;
        m_cmp = c; m_msk = m;
    endtask

    task automatic search(input string req);
        @(negedge clk);
        srch = 1'b1;
        predict();
        @(negedge clk);
        srch = 1'b0;
        chk(req, "done", 32'(done), 32'd1);
        check_all(req);
    endtask

    function automatic logic [W-1:0] pattern(input int i);
        return {12'(12'h111 * (i % 3)), 4'(i), 8'(i * 37 + 5)};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < N; i++) begin m_word[i] = '0; m_val[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "tags", 32'(tags), 0);
        chk("R1", "hit", 32'(hit), 0);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "hit_cnt", 32'(hit_cnt), 0);
        // R1 R5: zero mask after reset, nothing valid
        search("R1");

        // R2: fill every entry
        for (int i = 0; i < N; i++) write(i, pattern(i), 1'b1);
        // R4: zero mask matches all valid entries
        load(24'hABCDEF, '0);
        search("R4");
        chk("R8", "all count", 32'(hit_cnt), N);

        // R4 R7 R8: sweep key field values 0..3 (key 3 has no match -> R9)
        for (int k = 0; k < 4; k++) begin
            load({12'(12'h111 * k), 12'h0}, M_KEY);
            search(k == 3 ? "R9" : "R7");
        end
        // R4: class field sweep
        for (int c = 0; c < N + 2; c++) begin
            load({12'h0, 4'(c), 8'h0}, M_CLS);
            search("R4");
        end
        // R7: exact full-word search for every entry
        for (int i = 0; i < N; i++) begin
            load(pattern(i), '1);
            search("R7");
        end
        // R4: single-bit masks sweep over payload bits
        for (int b = 0; b < 8; b++) begin
            load(24'h0000FF, 24'(1) << b);
            search("R8");
        end

        // R2 R5: invalidate entries 0 and 3, zero and key masks
        write(0, 24'h0, 1'b0);
        write(3, 24'h0, 1'b0);
        load('0, '0);
        search("R5");
        load(pattern(3), '1);
        search("R5");
        load({12'h000, 12'h0}, M_KEY);
        search("R5");

        // R6: outputs hold across idle cycles and writes
        load('0, M_PAY);
        search("R6");
        write(6, 24'h123456, 1'b1);
        write(7, 24'h000000, 1'b0);
        repeat (3) @(negedge clk);
        chk("R6", "done idle", 32'(done), 0);
        check_all("R6");

        // R3: comparand load coincident with search affects next search only
        load(pattern(1), '1);
        @(negedge clk);
        srch = 1'b1; cmp_ld = 1'b1; ld_data = 24'h123456;
        predict();
        @(negedge clk);
        srch = 1'b0; cmp_ld = 1'b0;
        check_all("R3");
        m_cmp = 24'h123456;
        search("R3");

        // R10: write coincident with search sees old contents
        load(pattern(2), '1);
        @(negedge clk);
        srch = 1'b1; wr_en = 1'b1; wr_idx = 3'd2; wr_data = 24'hFEDCBA; wr_valid = 1'b1;
        predict();
        @(negedge clk);
        srch = 1'b0; wr_en = 1'b0;
        check_all("R10");
        m_word[2] = 24'hFEDCBA; m_val[2] = 1'b1;
        search("R10");
        // R10: invalidate coincident with search still finds old entry
        load(24'hFEDCBA, '1);
        @(negedge clk);
        srch = 1'b1; wr_en = 1'b1; wr_idx = 3'd2; wr_valid = 1'b0;
        predict();
        @(negedge clk);
        srch = 1'b0; wr_en = 1'b0;
        check_all("R10");
        m_val[2] = 1'b0;
        search("R10");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule